// File: doc/BRIEF.md
# Strobe-Gated Flash Timeout Controller

This block decides, cycle by cycle, when each of four LED current sinks may conduct. Every output has an enable bit held in the block. An output that is not tied to any enabled strobe pin starts as soon as its bit is set. An output that is tied to one or both strobe pins waits for them. Each pin is individually level- or edge-sensitive. A programmable time-out, counted in 1 ms ticks, ends every pulse. A fault input stops everything at once.

A time-out or a fault does different things depending on how the output was started. For an output started by its register bit, the block clears that enable bit, so software has to set it again. For a strobe-driven output, the enable bit stays set, so the next strobe fires again without any software action. Each time-out also sets a sticky per-output flag. The flag is status only and is cleared by an acknowledge pulse.

Top module: `flash_gate_ctrl`

## Requirements
- R1: A cycle with `en_wr_i` high loads `en_wdata_i` into the enable vector, which appears on `en_o` after the next clock edge. An output is never on while its `en_o` bit is 0.
- R2: An output is unassigned when no enabled strobe maps to it. An unassigned output turns on at the clock edge that loads its enable bit as 1.
- R3: The time-out code is `tcfg_i[3:0]`. Codes 0..9 give 10·(code+1) ticks, and codes 10..15 give 150 + 50·(code−10) ticks. `tcfg_i[4]` = 1 multiplies the result by 4. An output goes off at the edge of the tick that completes that count, counting ticks from its turn-on.
- R4: With `tcfg_i[5]` = 1, no time-out occurs and no flag is set. The output stays on however many ticks arrive.
- R5: A time-out or fault on an unassigned output clears its enable bit. An output assigned to an enabled strobe keeps its enable bit through a time-out.
- R6: A level-mode strobe (select bit 0) drives its assigned outputs from the pin level. The output stays off while the pin is low. A time-out cuts it off and holds it off until the pin has been seen low.
- R7: An edge-mode strobe (select bit 1) starts a pulse on a rising pin edge. The pulse then lasts until time-out or fault, whatever the pin does.
- R8: `str_map_i[i]` maps output i to strobe 1, and `str_map_i[4+i]` maps output i to strobe 2. A mapping to a strobe whose `strobe_en_i` bit is 0 is ignored. An output mapped to both strobes is driven by the OR of the two.
- R9: Each time-out sets `to_flag_o[i]` until a cycle with `flag_ack_i` high clears it. A set flag does not stop the output from starting again.
- R10: While `fault_i` is high, every output is off from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| str_map_i | input | 8 | Strobe-to-output map: [3:0] strobe 1, [7:4] strobe 2 |
| en_wr_i | input | 1 | Enable vector write strobe |
| en_wdata_i | input | 4 | Enable vector write data |
| strobe_i | input | 2 | Strobe pins (bit 0 strobe 1, bit 1 strobe 2) |
| strobe_en_i | input | 2 | Per-strobe pin enable |
| tcfg_i | input | 8 | [3:0] time-out code, [4] x4, [5] time-out off, [6] strobe 1 edge select, [7] strobe 2 edge select |
| fault_i | input | 1 | Fault: forces all outputs off |
| tick_ms_i | input | 1 | One-cycle 1 ms tick |
| flag_ack_i | input | 1 | Clears the time-out flags |
| led_on_o | output | 4 | Per-output drive |
| en_o | output | 4 | Current enable vector |
| to_flag_o | output | 4 | Sticky time-out flags |

## Verification
The assertions check four properties on every cycle:
- no output is on with its enable bit clear;
- a fault empties all outputs on the next edge;
- each time-out sets its flag;
- auto-clearing really drops the enable bit, and no flag rises while the time-out is disabled.

Some behaviour shows only in the bench's scenarios, because it needs whole sequences:
- the exact pulse length for each code and multiplier;
- the level-mode lockout and re-arm;
- an edge pulse outliving its pin;
- a mapping to a disabled strobe being ignored;
- the OR of two strobes.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
    localparam int unsigned TMO_W  = 11;
    localparam int unsigned CODE_W = 4;

    typedef struct packed {
        logic             on;
        logic             pulse;
        logic             lock;
        logic             flag;
        logic [TMO_W-1:0] cnt;
    } chan_t;
endpackage

// File: rtl/timeout_decode.sv
module timeout_decode
    import flash_gate_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              x4_i,
    output logic [TMO_W-1:0]  limit_o
);
    logic [TMO_W-1:0] c;
    logic [TMO_W-1:0] base;

    always_comb begin
        c = TMO_W'(code_i);
        if (code_i < CODE_W'(10))
            base = (c << 3) + (c << 1) + TMO_W'(10);
        else
            base = (c << 5) + (c << 4) + (c << 1) - TMO_W'(350);
        limit_o = x4_i ? (base << 2) : base;
    end
endmodule

// File: rtl/strobe_sense.sv
module strobe_sense #(
    parameter int unsigned N_STR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STR-1:0] pin_i,
    input  logic [N_STR-1:0] pin_en_i,
    input  logic [N_STR-1:0] edge_sel_i,
    output logic [N_STR-1:0] lvl_o,
    output logic [N_STR-1:0] rise_o
);
    logic [N_STR-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pin_i;
        lvl_o  = pin_i & pin_en_i & ~edge_sel_i;
        rise_o = pin_i & ~prev_q & pin_en_i & edge_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/out_channel.sv
module out_channel
    import flash_gate_pkg::*;
#(
    parameter int unsigned N_STR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_nx_i,
    input  logic [N_STR-1:0] map_i,
    input  logic [N_STR-1:0] str_en_i,
    input  logic [N_STR-1:0] lvl_i,
    input  logic [N_STR-1:0] rise_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             tmo_dis_i,
    input  logic             fault_i,
    input  logic             ack_i,
    output logic             on_o,
    output logic             flag_o,
    output logic             clr_o
);
    chan_t r_d, r_q;
    logic  asg, lvl_req, e_start, expire, on_nx;

    always_comb begin
        r_d     = r_q;
        asg     = |(map_i & str_en_i);
        lvl_req = |(map_i & lvl_i);
        e_start = |(map_i & rise_i);
        expire  = r_q.on & tick_i & ~tmo_dis_i & (r_q.cnt == limit_i - 1'b1);
        clr_o   = ~asg & (expire | fault_i);

        r_d.flag  = (r_q.flag & ~ack_i) | expire;
        r_d.lock  = expire | fault_i | (r_q.lock & lvl_req);
        r_d.pulse = en_nx_i & ~fault_i & ~expire & (r_q.pulse | e_start);
        on_nx     = en_nx_i & ~fault_i & ~expire &
                    (asg ? (r_d.pulse | (lvl_req & ~r_d.lock)) : 1'b1);
        r_d.on    = on_nx;

        if (on_nx && r_q.on) begin
            if (tick_i && (r_q.cnt < limit_i - 1'b1))
                r_d.cnt = r_q.cnt + 1'b1;
        end else begin
            r_d.cnt = '0;
        end

        on_o   = r_q.on;
        flag_o = r_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R10: a fault empties this output on the next edge
    a_r10_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !r_q.on);

    // R9: every time-out leaves its flag set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.flag);

    // R4: no flag rises while the time-out was disabled
    a_r4_no_flag_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmo_dis_i) |-> !$rose(r_q.flag));
endmodule

// File: rtl/flash_gate_ctrl.sv
module flash_gate_ctrl
    import flash_gate_pkg::*;
#(
    parameter int unsigned N_OUT = 4,
    parameter int unsigned N_STR = 2,
    localparam int unsigned MAP_W = N_OUT * N_STR,
    localparam int unsigned CFG_W = CODE_W + 2 + N_STR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAP_W-1:0] str_map_i,
    input  logic             en_wr_i,
    input  logic [N_OUT-1:0] en_wdata_i,
    input  logic [N_STR-1:0] strobe_i,
    input  logic [N_STR-1:0] strobe_en_i,
    input  logic [CFG_W-1:0] tcfg_i,
    input  logic             fault_i,
    input  logic             tick_ms_i,
    input  logic             flag_ack_i,
    output logic [N_OUT-1:0] led_on_o,
    output logic [N_OUT-1:0] en_o,
    output logic [N_OUT-1:0] to_flag_o
);
    logic [N_OUT-1:0] en_d, en_q, clr;
    logic [N_STR-1:0] lvl, rise;
    logic [TMO_W-1:0] limit;

    timeout_decode u_dec (
        .code_i  (tcfg_i[CODE_W-1:0]),
        .x4_i    (tcfg_i[CODE_W]),
        .limit_o (limit)
    );

    strobe_sense #(.N_STR(N_STR)) u_str (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (strobe_i),
        .pin_en_i   (strobe_en_i),
        .edge_sel_i (tcfg_i[CFG_W-1:CODE_W+2]),
        .lvl_o      (lvl),
        .rise_o     (rise)
    );

    always_comb begin
        en_d = (en_wr_i ? en_wdata_i : en_q) & ~clr;
        en_o = en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_ch
        logic [N_STR-1:0] map_col;
        for (genvar s = 0; s < N_STR; s++) begin : g_map
            assign map_col[s] = str_map_i[s*N_OUT + i];
        end

        out_channel #(.N_STR(N_STR)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_nx_i   (en_d[i]),
            .map_i     (map_col),
            .str_en_i  (strobe_en_i),
            .lvl_i     (lvl),
            .rise_i    (rise),
            .tick_i    (tick_ms_i),
            .limit_i   (limit),
            .tmo_dis_i (tcfg_i[CODE_W+1]),
            .fault_i   (fault_i),
            .ack_i     (flag_ack_i),
            .on_o      (led_on_o[i]),
            .flag_o    (to_flag_o[i]),
            .clr_o     (clr[i])
        );

        // R1: an output never conducts with its enable bit clear
        a_r1_on_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            !en_o[i] |-> !led_on_o[i]);

        // R5: an auto-clear request drops the enable bit
        a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !en_o[i]);
    end
endmodule

// File: tb/tb_flash_gate_ctrl.sv
`timescale 1ns/1ps
module tb_flash_gate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] str_map = '0;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = '0;
    logic [1:0] strobe = '0;
    logic [1:0] strobe_en = '0;
    logic [7:0] tcfg = '0;
    logic       fault = 1'b0;
    logic       tick = 1'b0;
    logic       ack = 1'b0;
    logic [3:0] led_on, en_v, flags;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    flash_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .str_map_i(str_map), .en_wr_i(en_wr),
        .en_wdata_i(en_wdata), .strobe_i(strobe), .strobe_en_i(strobe_en),
        .tcfg_i(tcfg), .fault_i(fault), .tick_ms_i(tick), .flag_ack_i(ack),
        .led_on_o(led_on), .en_o(en_v), .to_flag_o(flags)
    );

    always #5 clk = ~clk;

    function automatic int exp_limit(input int code, input int x4);
        int b;
        if (code <= 9) b = 10 * (code + 1);
        else           b = 150 + 50 * (code - 10);
        return x4 != 0 ? 4 * b : b;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [3:0] v);
        en_wr = 1'b1; en_wdata = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1; step();
        tick = 1'b0; step();
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic measure(input int idx, input int maxt, output int n);
        n = 0;
        while (n < maxt) begin
            pulse_tick();
            n++;
            if (!led_on[idx]) break;
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 reset led_on", int'(led_on), 0);
        chk("R1 reset en", int'(en_v), 0);
        chk("R9 reset flags", int'(flags), 0);

        // R2 / R3 unassigned output, code 0
        tcfg = 8'h00;
        write_en(4'b0001);
        chk("R2 unassigned turn-on", int'(led_on), 1);
        chk("R1 enable loaded", int'(en_v), 1);
        measure(0, 100, n);
        chk("R3 code0 ticks", n, exp_limit(0, 0));
        chk("R5 unassigned auto-clear", int'(en_v), 0);
        chk("R9 flag set", int'(flags), 1);

        // R9 restart with flag set, then acknowledge
        write_en(4'b0001);
        chk("R9 restart despite flag", int'(led_on[0]), 1);
        do_ack(); step();
        chk("R9 ack clears", int'(flags), 0);
        // R10 fault
        fault = 1'b1; step();
        chk("R10 fault off", int'(led_on), 0);
        chk("R5 fault clears unassigned en", int'(en_v), 0);
        fault = 1'b0; step();

        // R3 code 10 and code 15 with x4
        tcfg = 8'h0A;
        write_en(4'b0001);
        measure(0, 300, n);
        chk("R3 code10 ticks", n, exp_limit(10, 0));
        tcfg = 8'h1F;
        write_en(4'b0001);
        measure(0, 2000, n);
        chk("R3 code15 x4 ticks", n, exp_limit(15, 1));

        // R4 time-out disabled
        do_ack();
        tcfg = 8'h20;
        write_en(4'b0001);
        repeat (50) pulse_tick();
        chk("R4 still on", int'(led_on[0]), 1);
        chk("R4 no flag", int'(flags), 0);
        write_en(4'b0000);
        chk("R1 cleared enable turns off", int'(led_on), 0);

        // R6 level strobe 1 drives output 1
        tcfg = 8'h00; str_map = 8'h02; strobe_en = 2'b01;
        write_en(4'b0010);
        chk("R6 waits for pin", int'(led_on), 0);
        strobe = 2'b01; step();
        chk("R6 pin high on", int'(led_on), 2);
        strobe = 2'b00; step();
        chk("R6 pin low off", int'(led_on), 0);
        strobe = 2'b01; step();
        measure(1, 100, n);
        chk("R6 level time-out ticks", n, exp_limit(0, 0));
        chk("R5 assigned keeps en", int'(en_v), 2);
        step(); step(); step();
        chk("R6 locked while high", int'(led_on), 0);
        strobe = 2'b00; step();
        strobe = 2'b01; step();
        chk("R6 re-armed", int'(led_on), 2);
        strobe = 2'b00; step();

        // R7 edge strobe 2 drives output 2
        str_map = 8'h40; strobe_en = 2'b10; tcfg = 8'h80;
        write_en(4'b0100);
        chk("R7 waits for edge", int'(led_on), 0);
        strobe = 2'b10; step();
        chk("R7 edge on", int'(led_on), 4);
        strobe = 2'b00; step();
        chk("R7 pin drop ignored", int'(led_on), 4);
        measure(2, 100, n);
        chk("R7 edge time-out ticks", n, exp_limit(0, 0));
        chk("R5 edge keeps en", int'(en_v), 4);

        // R8 mapping to disabled strobe ignored
        str_map = 8'h08; strobe_en = 2'b00; tcfg = 8'h00;
        write_en(4'b1000);
        chk("R8 disabled strobe unassigned", int'(led_on), 8);
        write_en(4'b0000);

        // R8 OR of two level strobes
        str_map = 8'h11; strobe_en = 2'b11;
        write_en(4'b0001);
        chk("R8 both mapped waits", int'(led_on), 0);
        strobe = 2'b10; step();
        chk("R8 strobe2 alone drives", int'(led_on), 1);
        strobe = 2'b01; step();
        chk("R8 strobe1 alone drives", int'(led_on), 1);
        strobe = 2'b00; step();
        chk("R8 both low off", int'(led_on), 0);
        write_en(4'b0000);

        // R3 random codes on unassigned outputs
        str_map = 8'h00; strobe_en = 2'b00;
        void'($urandom(32'd2024));
        for (int k = 0; k < 16; k++) begin
            int code, x4, idx;
            code = int'($urandom % 16);
            x4   = (code < 4) ? int'($urandom % 2) : 0;
            idx  = int'($urandom % 4);
            tcfg = {3'b000, x4[0], code[3:0]};
            write_en(4'(1 << idx));
            measure(idx, 2000, n);
            chk("R3 random code ticks", n, exp_limit(code, x4));
            chk("R5 random auto-clear", int'(en_v), 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule